// File: doc/BRIEF.md
# Compacting Breakpoint Address Table

A small associative store of code breakpoints for a processor debug unit. Each live entry pairs a 32-bit instruction address with a 2-bit type code; type zero is reserved and means "no breakpoint". A debugger-side port can insert an entry, delete one, or wipe the whole table. A separate lookup port takes the current fetch address and returns, in the same cycle, the type of the lowest-indexed live entry with that address, or zero when no entry matches.

Live entries always occupy slots 0 to count-1 with no gaps. An insert goes into the slot indexed by the current count. A delete must match both address and type, and it picks the first such slot scanning upward from slot 0. Every slot above the deleted one then moves down by one in a single clock. Duplicate addresses are allowed, and the oldest one has lookup priority.

Top module: `bkpt_table`

## Requirements
- R1: After reset, or one cycle after an accepted clear, count_o is 0 and every lookup returns type 0.
- R2: An accepted insert with a nonzero type and count below DEPTH (16) stores the entry at slot count, and count_o is one higher after the clock edge.
- R3: full_o is high exactly when count_o equals DEPTH. An accepted insert while full leaves the table unchanged, and add_drop_o is high for the single cycle after it.
- R4: An accepted insert with type 0 leaves count_o and all lookups unchanged.
- R5: An accepted delete whose address and type both match a live entry removes the lowest such slot and shifts every later slot down by one. count_o then drops by one, and rm_done_o and rm_ok_o are both high in the next cycle.
- R6: An accepted delete that matches no live entry on both fields, including a same-address entry of a different type, leaves the table unchanged. In the next cycle rm_done_o is high and rm_ok_o is low.
- R7: lookup_type_o is combinational. It compares the address only and returns the type of the lowest-indexed live match, or 0 on a miss.
- R8: Slots at index count or above never match a lookup, even when they still hold stale data.
- R9: Clear takes priority over delete, and delete over insert. rm_ready_o = !clear_i and add_ready_o = !clear_i && !rm_req_i, and a request that is not accepted has no effect.
- R10: A lookup in the same cycle as an insert, delete or clear sees the table contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Empty the table |
| add_req_i | input | 1 | Insert request |
| add_addr_i | input | 32 | Insert address |
| add_type_i | input | 2 | Insert type code |
| add_ready_o | output | 1 | Insert accepted this cycle when high |
| rm_req_i | input | 1 | Delete request |
| rm_addr_i | input | 32 | Delete address |
| rm_type_i | input | 2 | Delete type code |
| rm_ready_o | output | 1 | Delete accepted this cycle when high |
| rm_done_o | output | 1 | Pulse: a delete completed last cycle |
| rm_ok_o | output | 1 | With rm_done_o: 1 if an entry was removed |
| add_drop_o | output | 1 | Pulse: an insert was dropped because the table was full |
| full_o | output | 1 | Table holds DEPTH entries |
| count_o | output | 5 | Number of live entries |
| lookup_addr_i | input | 32 | Fetch address to look up |
| lookup_type_o | output | 2 | Matching type, 0 on a miss |

## Verification
The assertions assume that a request counts only when its ready is high. They also assume that the type seen with an insert is the one on add_type_i during the accepting cycle, so any request held while not ready is treated as idle. The stimulus drives every input, including requests that collide with clear or with each other. It draws addresses from a pool of six values so that duplicates, same-address different-type deletes and deletes of missing entries occur often. The expected values come from a reference table in the bench that applies the same priority rule.

// File: rtl/bkpt_pkg.sv
`timescale 1ns/1ps
package bkpt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_REMOVE = 2'd2,
    OP_ADD    = 2'd3
  } op_e;
endpackage

// File: rtl/bkpt_store.sv
`timescale 1ns/1ps
module bkpt_store #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [CNT_W-1:0]               wr_idx_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [TYPE_W-1:0]              wr_type_i,
  input  logic                           sh_en_i,
  input  logic [IDX_W-1:0]               sh_idx_i,
  output logic [DEPTH-1:0][ADDR_W-1:0]   addr_o,
  output logic [DEPTH-1:0][TYPE_W-1:0]   type_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic shift_here;
    assign shift_here = sh_en_i && (IDX_W'(g) >= sh_idx_i);
    if (g < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_o[g] <= '0;
          type_o[g] <= '0;
        end else if (shift_here) begin
          addr_o[g] <= addr_o[g+1];
          type_o[g] <= type_o[g+1];
        end else if (wr_en_i && wr_idx_i == CNT_W'(g)) begin
          addr_o[g] <= wr_addr_i;
          type_o[g] <= wr_type_i;
        end
      end
    end else begin : g_top
      // top slot has no source above; a shift leaves it stale (outside count)
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          addr_o[g] <= '0;
          type_o[g] <= '0;
        end else if (!shift_here && wr_en_i && wr_idx_i == CNT_W'(g)) begin
          addr_o[g] <= wr_addr_i;
          type_o[g] <= wr_type_i;
        end
      end
    end
  end
endmodule

// File: rtl/bkpt_find.sv
`timescale 1ns/1ps
module bkpt_find #(
  parameter int DEPTH      = 16,
  parameter int ADDR_W     = 32,
  parameter int TYPE_W     = 2,
  parameter bit MATCH_TYPE = 1'b0,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
  input  logic [DEPTH-1:0][TYPE_W-1:0] type_i,
  input  logic [CNT_W-1:0]             count_i,
  input  logic [ADDR_W-1:0]            key_addr_i,
  input  logic [TYPE_W-1:0]            key_type_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [TYPE_W-1:0]            type_o
);
  logic [DEPTH-1:0] match;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic live, addr_eq;
    assign live    = CNT_W'(g) < count_i;
    assign addr_eq = addr_i[g] == key_addr_i;
    if (MATCH_TYPE) begin : g_full
      assign match[g] = live && addr_eq && (type_i[g] == key_type_i);
    end else begin : g_addr
      logic unused_key;
      assign unused_key = ^key_type_i;
      assign match[g]   = live && addr_eq;
    end
  end

  // lowest index wins
  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    type_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(i);
        type_o = type_i[i];
      end
    end
  end
endmodule

// File: rtl/bkpt_table.sv
`timescale 1ns/1ps
module bkpt_table #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_req_i,
  input  logic [ADDR_W-1:0] add_addr_i,
  input  logic [TYPE_W-1:0] add_type_i,
  output logic              add_ready_o,
  input  logic              rm_req_i,
  input  logic [ADDR_W-1:0] rm_addr_i,
  input  logic [TYPE_W-1:0] rm_type_i,
  output logic              rm_ready_o,
  output logic              rm_done_o,
  output logic              rm_ok_o,
  output logic              add_drop_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic [TYPE_W-1:0] lookup_type_o
);
  import bkpt_pkg::*;

  op_e                         op;
  logic [CNT_W-1:0]            count_q;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][TYPE_W-1:0] ent_type;
  logic                        wr_en, sh_en, is_full;
  logic                        rm_hit, lk_hit;
  logic [IDX_W-1:0]            rm_idx, lk_idx;
  logic [TYPE_W-1:0]           rm_type_unused, lk_type;
  logic                        drop_q, done_q, ok_q;

  always_comb begin
    if (clear_i)        op = OP_CLEAR;
    else if (rm_req_i)  op = OP_REMOVE;
    else if (add_req_i) op = OP_ADD;
    else                op = OP_IDLE;
  end

  assign rm_ready_o  = !clear_i;
  assign add_ready_o = !clear_i && !rm_req_i;
  assign is_full     = count_q == CNT_W'(DEPTH);
  assign wr_en       = (op == OP_ADD) && !is_full && (add_type_i != '0);
  assign sh_en       = (op == OP_REMOVE) && rm_hit;

  bkpt_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (count_q),
    .wr_addr_i (add_addr_i),
    .wr_type_i (add_type_i),
    .sh_en_i   (sh_en),
    .sh_idx_i  (rm_idx),
    .addr_o    (ent_addr),
    .type_o    (ent_type)
  );

  bkpt_find #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .MATCH_TYPE(1'b1)) u_rm_find (
    .addr_i     (ent_addr),
    .type_i     (ent_type),
    .count_i    (count_q),
    .key_addr_i (rm_addr_i),
    .key_type_i (rm_type_i),
    .hit_o      (rm_hit),
    .idx_o      (rm_idx),
    .type_o     (rm_type_unused)
  );

  bkpt_find #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .MATCH_TYPE(1'b0)) u_lk_find (
    .addr_i     (ent_addr),
    .type_i     (ent_type),
    .count_i    (count_q),
    .key_addr_i (lookup_addr_i),
    .key_type_i ('0),
    .hit_o      (lk_hit),
    .idx_o      (lk_idx),
    .type_o     (lk_type)
  );

  logic unused_ok;
  assign unused_ok = ^{lk_idx, rm_type_unused};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      drop_q  <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      if (op == OP_CLEAR) count_q <= '0;
      else if (wr_en)     count_q <= count_q + 1'b1;
      else if (sh_en)     count_q <= count_q - 1'b1;
      drop_q <= (op == OP_ADD) && is_full;
      done_q <= op == OP_REMOVE;
      ok_q   <= sh_en;
    end
  end

  assign count_o       = count_q;
  assign full_o        = is_full;
  assign add_drop_o    = drop_q;
  assign rm_done_o     = done_q;
  assign rm_ok_o       = ok_q;
  assign lookup_type_o = lk_hit ? lk_type : '0;
endmodule

// File: rtl/bkpt_table_chk.sv
`timescale 1ns/1ps
module bkpt_table_chk #(
  parameter int DEPTH  = 16,
  parameter int TYPE_W = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic              add_req_i,
  input logic [TYPE_W-1:0] add_type_i,
  input logic              add_ready_o,
  input logic              rm_req_i,
  input logic              rm_ready_o,
  input logic              rm_done_o,
  input logic              rm_ok_o,
  input logic              add_drop_o,
  input logic              full_o,
  input logic [CNT_W-1:0]  count_o,
  input logic [TYPE_W-1:0] lookup_type_o
);
  assert_clear_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);

  assert_add_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_req_i && add_ready_o && !full_o && add_type_i != '0) |=> count_o == $past(count_o) + 1'b1);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_req_i && add_ready_o && full_o) |=> (add_drop_o && $stable(count_o)));

  assert_type_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_req_i && add_ready_o && add_type_i == '0) |=> $stable(count_o));

  assert_rm_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rm_req_i && rm_ready_o) |=> rm_done_o);

  assert_rm_shrink_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rm_done_o && rm_ok_o) |-> count_o == $past(count_o) - 1'b1);

  assert_rm_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rm_done_o && !rm_ok_o) |-> $stable(count_o));

  assert_empty_miss_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == '0 |-> lookup_type_o == '0);

  assert_ok_needs_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rm_ok_o |-> rm_done_o);
endmodule

bind bkpt_table bkpt_table_chk #(.DEPTH(DEPTH), .TYPE_W(TYPE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clear_i       (clear_i),
  .add_req_i     (add_req_i),
  .add_type_i    (add_type_i),
  .add_ready_o   (add_ready_o),
  .rm_req_i      (rm_req_i),
  .rm_ready_o    (rm_ready_o),
  .rm_done_o     (rm_done_o),
  .rm_ok_o       (rm_ok_o),
  .add_drop_o    (add_drop_o),
  .full_o        (full_o),
  .count_o       (count_o),
  .lookup_type_o (lookup_type_o)
);

// File: tb/sim_bkpt_table.sv
`timescale 1ns/1ps
module sim_bkpt_table;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 0, add_req = 0, rm_req = 0;
  logic [31:0] add_addr = 0, rm_addr = 0, lk_addr = 0;
  logic [1:0]  add_type = 0, rm_type = 0;
  logic        add_ready, rm_ready, rm_done, rm_ok, add_drop, full;
  logic [4:0]  count;
  logic [1:0]  lk_type;

  int total = 0, bad = 0;

  logic [31:0] m_addr [DEPTH];
  logic [1:0]  m_type [DEPTH];
  int          m_cnt = 0;

  always #2.5 clk = ~clk;

  bkpt_table u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .add_req_i(add_req), .add_addr_i(add_addr), .add_type_i(add_type), .add_ready_o(add_ready),
    .rm_req_i(rm_req), .rm_addr_i(rm_addr), .rm_type_i(rm_type), .rm_ready_o(rm_ready),
    .rm_done_o(rm_done), .rm_ok_o(rm_ok), .add_drop_o(add_drop), .full_o(full),
    .count_o(count), .lookup_addr_i(lk_addr), .lookup_type_o(lk_type)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_lookup(input logic [31:0] a);
    for (int i = 0; i < m_cnt; i++)
      if (m_addr[i] == a) return m_type[i];
    return 2'd0;
  endfunction

  function automatic int ref_find(input logic [31:0] a, input logic [1:0] t);
    for (int i = 0; i < m_cnt; i++)
      if (m_addr[i] == a && m_type[i] == t) return i;
    return -1;
  endfunction

  task automatic cyc(input bit c, input bit ad, input logic [31:0] aa, input logic [1:0] at,
                     input bit rm, input logic [31:0] ra, input logic [1:0] rt, input logic [31:0] la);
    bit a_fire, r_fire, e_drop, e_ok;
    int hit;
    string tag;
    @(negedge clk);
    clear = c; add_req = ad; add_addr = aa; add_type = at;
    rm_req = rm; rm_addr = ra; rm_type = rt; lk_addr = la;
    #1;
    tag = (c || ad || rm) ? "R10" : "R7";
    chk(lk_type == ref_lookup(la), tag, lk_type, ref_lookup(la));
    chk(rm_ready == !c, "R9", rm_ready, !c);
    chk(add_ready == (!c && !rm), "R9", add_ready, (!c && !rm));
    r_fire = rm && !c;
    a_fire = ad && !rm && !c;
    e_drop = a_fire && m_cnt == DEPTH;
    e_ok = 1'b0;
    if (c) begin
      m_cnt = 0; tag = "R1";
    end else if (r_fire) begin
      hit = ref_find(ra, rt);
      if (hit >= 0) begin
        for (int i = hit; i < m_cnt - 1; i++) begin
          m_addr[i] = m_addr[i+1]; m_type[i] = m_type[i+1];
        end
        m_cnt--; e_ok = 1'b1; tag = "R5";
      end else tag = "R6";
    end else if (a_fire) begin
      if (m_cnt == DEPTH) tag = "R3";
      else if (at == 2'd0) tag = "R4";
      else begin
        m_addr[m_cnt] = aa; m_type[m_cnt] = at; m_cnt++; tag = "R2";
      end
    end else tag = (ad || rm) ? "R9" : "R7";
    @(posedge clk);
    #1;
    chk(count == 5'(m_cnt), tag, count, m_cnt);
    chk(full == (m_cnt == DEPTH), "R3", full, (m_cnt == DEPTH));
    chk(add_drop == e_drop, "R3", add_drop, e_drop);
    chk(rm_done == r_fire, tag, rm_done, r_fire);
    chk(rm_ok == e_ok, tag, rm_ok, e_ok);
    chk(lk_type == ref_lookup(la), tag, lk_type, ref_lookup(la));
  endtask

  task automatic idle(input logic [31:0] la);
    cyc(0, 0, 0, 0, 0, 0, 0, la);
  endtask

  task automatic add(input logic [31:0] a, input logic [1:0] t);
    cyc(0, 1, a, t, 0, 0, 0, a);
  endtask

  task automatic del(input logic [31:0] a, input logic [1:0] t);
    cyc(0, 0, 0, 0, 1, a, t, a);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(count == 0, "R1", count, 0);
    chk(lk_type == 0, "R1", lk_type, 0);
    rst_n = 1'b1;
    idle(32'h0);

    // R2/R3: fill to 16, overflow add dropped
    for (int i = 0; i < DEPTH; i++) add(32'h1000 + 32'(i) * 4, 2'(1 + i % 3));
    add(32'h2000, 2'd1);
    idle(32'h2000);
    for (int i = 0; i < DEPTH; i++) idle(32'h1000 + 32'(i) * 4);

    // R5: middle removal shifts later slots
    del(32'h1000 + 5 * 4, 2'(1 + 5 % 3));
    idle(32'h1000 + 5 * 4);
    idle(32'h1000 + 6 * 4);
    // R6: same address, wrong type; missing address
    del(32'h1000 + 7 * 4, 2'd3);
    del(32'h3000, 2'd1);
    // R8: remove last live slot; stale slot must not match
    del(32'h1000 + 15 * 4, 2'(1 + 15 % 3));
    idle(32'h1000 + 15 * 4);
    // R1: clear then lookups miss
    cyc(1, 0, 0, 0, 0, 0, 0, 32'h1000);
    idle(32'h1000 + 4);

    // R4: type zero insert ignored
    add(32'h4000, 2'd0);
    idle(32'h4000);
    // R7: duplicates, lowest index wins; delete exposes next
    add(32'h5000, 2'd2);
    add(32'h5000, 2'd3);
    idle(32'h5000);
    del(32'h5000, 2'd2);
    idle(32'h5000);
    // R9: collisions
    cyc(0, 1, 32'h6000, 2'd1, 1, 32'h5000, 2'd3, 32'h6000);
    cyc(1, 1, 32'h6000, 2'd1, 1, 32'h5000, 2'd3, 32'h6000);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom % 100);
      cyc(r < 2, ($urandom % 100) < 45, 32'h8000_0000 + ($urandom % 6) * 4, 2'($urandom % 4),
          ($urandom % 100) < 25, 32'h8000_0000 + ($urandom % 6) * 4, 2'($urandom % 4),
          32'h8000_0000 + ($urandom % 7) * 4);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule